// File: doc/BRIEF.md
# Flow Statistics Record Updater

This block keeps one statistics record per traffic flow in a private single-port record memory. Each accepted packet descriptor names a record slot, an operation and the packet's length, arrival timestamp, TCP flag bits and flow key. The engine creates a fresh record, or it reads the stored record and writes it back with the new packet folded in, or it exports the stored record and empties the slot.

On every fold-in the engine also measures how long the flow has been alive. The age is the gap between the packet's timestamp and the record's first timestamp, taken modulo 2^32. A flow older than the software-set active timeout is pushed out on the export stream, and the packet then opens a new record in the same slot. Flow lookup (key to slot index) and idle aging happen upstream; this block only acts on the index it is given.

Descriptors arrive over a valid/ready handshake. Exported records leave over a second valid/ready handshake. While an export waits for its consumer, the engine takes no new descriptor.

Top module: `flow_rec_engine`

## Requirements
- R1: After reset `in_ready` is 1 and `exp_valid` is 0.
- R2: Operation code 0 (create) writes a record with first and last timestamp equal to the packet timestamp, packet count 1, byte count equal to the packet length, the packet's flags and the packet's key fields.
- R3: Operation code 1 (update) sets the last timestamp to the packet timestamp, adds 1 to the packet count and adds the packet length to the byte count. The stored key and first timestamp stay unchanged.
- R4: An update merges the packet's flags into the stored flags with a bitwise OR.
- R5: An update counts as expired only when (packet timestamp − stored first timestamp) mod 2^32 is strictly greater than `active_timeout`. An age equal to the timeout does not expire.
- R6: The age test gives the correct result when the timestamp wraps past 2^32−1.
- R7: On expiry the engine exports the merged record, which includes the current packet, with `exp_aged`=1. The slot then holds a new record built from that packet alone, as in R2.
- R8: Operation code 2 (delete) exports the stored record unchanged with `exp_aged`=0 and then clears every field of the slot to zero.
- R9: While `exp_valid` is 1 and `exp_ready` is 0, the export payload holds steady and `in_ready` stays 0.
- R10: Operation code 3 is accepted but changes no record and exports nothing.
- R11: `exp_idx` carries the slot index of the descriptor that caused the export.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| active_timeout | input | 32 | Active flow timeout, in timestamp units |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Engine can accept a descriptor |
| in_idx | input | IDX_W | Record slot index |
| in_op | input | 2 | Operation: 0 create, 1 update, 2 delete, 3 no-op |
| in_len | input | 16 | Packet length in bytes |
| in_ts | input | 32 | Packet timestamp |
| in_flags | input | 8 | Packet TCP flags |
| in_src | input | 128 | Source address |
| in_dst | input | 128 | Destination address |
| in_sport | input | 16 | Source port |
| in_dport | input | 16 | Destination port |
| in_proto | input | 8 | Transport protocol |
| in_tos | input | 8 | Type of service |
| exp_valid | output | 1 | Export record valid |
| exp_ready | input | 1 | Export consumer ready |
| exp_idx | output | IDX_W | Slot index of the exported record |
| exp_aged | output | 1 | 1 = active-timeout export, 0 = delete export |
| exp_start | output | 32 | First timestamp |
| exp_end | output | 32 | Last timestamp |
| exp_bytes | output | 64 | Byte count |
| exp_pkts | output | 32 | Packet count |
| exp_flags | output | 8 | OR of flags |
| exp_src | output | 128 | Source address |
| exp_dst | output | 128 | Destination address |
| exp_sport | output | 16 | Source port |
| exp_dport | output | 16 | Destination port |
| exp_proto | output | 8 | Transport protocol |
| exp_tos | output | 8 | Type of service |

## Verification
The bench builds the engine with its default 4-bit index, which gives 16 slots, and drives it with a fixed timeout of 100. With that timeout, ages of exactly 100 and 101 are easy to produce, so both sides of the strict comparison get checked. The bench also places first timestamps a few counts below 2^32 so that both an expiring age and a non-expiring age cross the timestamp wrap. Every stored record is read back through a delete export. This makes accumulation, key retention, expiry refresh, no-op handling and clearing visible at the ports.

// File: rtl/flow_rec_pkg.sv
// Shared field widths, operation codes and the flow record layout.
// Assumes the record is kept whole in one memory word.
package flow_rec_pkg;
    parameter int TS_W    = 32;
    parameter int BYTE_W  = 64;
    parameter int PKT_W   = 32;
    parameter int FLAG_W  = 8;
    parameter int ADDR_W  = 128;
    parameter int PORT_W  = 16;
    parameter int PROTO_W = 8;
    parameter int TOS_W   = 8;
    parameter int LEN_W   = 16;

    typedef enum logic [1:0] {
        OP_NEW = 2'd0,
        OP_UPD = 2'd1,
        OP_DEL = 2'd2,
        OP_NOP = 2'd3
    } op_e;

    typedef struct packed {
        logic [TS_W-1:0]    start_ts;
        logic [TS_W-1:0]    end_ts;
        logic [BYTE_W-1:0]  bytes;
        logic [PKT_W-1:0]   pkts;
        logic [FLAG_W-1:0]  flags;
        logic [ADDR_W-1:0]  src;
        logic [ADDR_W-1:0]  dst;
        logic [PORT_W-1:0]  sport;
        logic [PORT_W-1:0]  dport;
        logic [PROTO_W-1:0] proto;
        logic [TOS_W-1:0]   tos;
    } flow_rec_t;

    localparam int REC_W = $bits(flow_rec_t);
endpackage

// File: rtl/flow_rec_mem.sv
// Single-port record store with a registered read port.
// Assumes one access per cycle; a read returns the word one cycle after
// the address is presented. The contents are not reset.
module flow_rec_mem #(
    parameter int IDX_W = 4,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [WIDTH-1:0] store [DEPTH];

    // Write the addressed word and register the addressed word for reading.
    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= wdata;
        end
        rdata <= store[addr];
    end
endmodule

// File: rtl/flow_rec_merge.sv
// Folds one packet into a stored flow record and computes the active-age test.
// Assumes `pkt` holds the packet in create-record form (bytes = length,
// pkts = 1, start = end = packet timestamp).
module flow_rec_merge
    import flow_rec_pkg::*;
(
    input  flow_rec_t       stored,
    input  flow_rec_t       pkt,
    input  logic [TS_W-1:0] timeout,
    output flow_rec_t       merged,
    output logic            expired
);
    logic [TS_W-1:0] age;

    // Accumulate the counters and flags; keep the stored key and first timestamp.
    always_comb begin
        merged        = stored;
        merged.end_ts = pkt.end_ts;
        merged.bytes  = stored.bytes + pkt.bytes;
        merged.pkts   = stored.pkts + PKT_W'(1);
        merged.flags  = stored.flags | pkt.flags;
    end

    // Age is taken modulo 2^TS_W, so it stays correct across timestamp wrap.
    always_comb begin
        age     = pkt.end_ts - stored.start_ts;
        expired = age > timeout;
    end
endmodule

// File: rtl/flow_rec_engine.sv
// Flow record update engine. Takes one descriptor at a time; it creates,
// updates or deletes the record at the given slot and exports records on
// delete or on active-timeout expiry. Assumes the slot index is supplied
// by an upstream lookup, and that a slot is created before it is updated.
module flow_rec_engine
    import flow_rec_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TS_W-1:0]    active_timeout,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [IDX_W-1:0]   in_idx,
    input  logic [1:0]         in_op,
    input  logic [LEN_W-1:0]   in_len,
    input  logic [TS_W-1:0]    in_ts,
    input  logic [FLAG_W-1:0]  in_flags,
    input  logic [ADDR_W-1:0]  in_src,
    input  logic [ADDR_W-1:0]  in_dst,
    input  logic [PORT_W-1:0]  in_sport,
    input  logic [PORT_W-1:0]  in_dport,
    input  logic [PROTO_W-1:0] in_proto,
    input  logic [TOS_W-1:0]   in_tos,
    output logic               exp_valid,
    input  logic               exp_ready,
    output logic [IDX_W-1:0]   exp_idx,
    output logic               exp_aged,
    output logic [TS_W-1:0]    exp_start,
    output logic [TS_W-1:0]    exp_end,
    output logic [BYTE_W-1:0]  exp_bytes,
    output logic [PKT_W-1:0]   exp_pkts,
    output logic [FLAG_W-1:0]  exp_flags,
    output logic [ADDR_W-1:0]  exp_src,
    output logic [ADDR_W-1:0]  exp_dst,
    output logic [PORT_W-1:0]  exp_sport,
    output logic [PORT_W-1:0]  exp_dport,
    output logic [PROTO_W-1:0] exp_proto,
    output logic [TOS_W-1:0]   exp_tos
);
    typedef enum logic [1:0] {S_IDLE, S_EVAL, S_EXPORT, S_WRITE} state_e;

    state_e           state;
    op_e              op_q;
    logic [IDX_W-1:0] idx_q;
    logic [TS_W-1:0]  tmo_q;
    flow_rec_t        fresh_d, fresh_q, wr_q, exp_q, rd_rec, merged;
    logic             aged_q, expired;
    logic [IDX_W-1:0] mem_addr;
    logic [REC_W-1:0] mem_rdata;
    logic             accept;

    assign in_ready = (state == S_IDLE);
    assign accept   = in_valid && in_ready;
    assign mem_addr = (state == S_IDLE) ? in_idx : idx_q;
    assign rd_rec   = flow_rec_t'(mem_rdata);

    // Build the create-record form of the incoming packet.
    always_comb begin
        fresh_d.start_ts = in_ts;
        fresh_d.end_ts   = in_ts;
        fresh_d.bytes    = BYTE_W'(in_len);
        fresh_d.pkts     = PKT_W'(1);
        fresh_d.flags    = in_flags;
        fresh_d.src      = in_src;
        fresh_d.dst      = in_dst;
        fresh_d.sport    = in_sport;
        fresh_d.dport    = in_dport;
        fresh_d.proto    = in_proto;
        fresh_d.tos      = in_tos;
    end

    flow_rec_mem #(.IDX_W(IDX_W), .WIDTH(REC_W)) u_mem (
        .clk   (clk),
        .we    (state == S_WRITE),
        .addr  (mem_addr),
        .wdata (wr_q),
        .rdata (mem_rdata)
    );

    flow_rec_merge u_merge (
        .stored  (rd_rec),
        .pkt     (fresh_q),
        .timeout (tmo_q),
        .merged  (merged),
        .expired (expired)
    );

    // Sequence each descriptor through read, evaluate, export and write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            op_q    <= OP_NOP;
            idx_q   <= '0;
            tmo_q   <= '0;
            fresh_q <= '0;
            wr_q    <= '0;
            exp_q   <= '0;
            aged_q  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (accept) begin
                    op_q    <= op_e'(in_op);
                    idx_q   <= in_idx;
                    tmo_q   <= active_timeout;
                    fresh_q <= fresh_d;
                    wr_q    <= fresh_d;
                    case (op_e'(in_op))
                        OP_NEW:  state <= S_WRITE;
                        OP_UPD,
                        OP_DEL:  state <= S_EVAL;
                        default: state <= S_IDLE;
                    endcase
                end
                S_EVAL: begin
                    if (op_q == OP_DEL) begin
                        exp_q  <= rd_rec;
                        aged_q <= 1'b0;
                        wr_q   <= '0;
                        state  <= S_EXPORT;
                    end else if (expired) begin
                        exp_q  <= merged;
                        aged_q <= 1'b1;
                        wr_q   <= fresh_q;
                        state  <= S_EXPORT;
                    end else begin
                        wr_q  <= merged;
                        state <= S_WRITE;
                    end
                end
                S_EXPORT: if (exp_ready) state <= S_WRITE;
                default:  state <= S_IDLE;
            endcase
        end
    end

    assign exp_valid = (state == S_EXPORT);
    assign exp_idx   = idx_q;
    assign exp_aged  = aged_q;
    assign exp_start = exp_q.start_ts;
    assign exp_end   = exp_q.end_ts;
    assign exp_bytes = exp_q.bytes;
    assign exp_pkts  = exp_q.pkts;
    assign exp_flags = exp_q.flags;
    assign exp_src   = exp_q.src;
    assign exp_dst   = exp_q.dst;
    assign exp_sport = exp_q.sport;
    assign exp_dport = exp_q.dport;
    assign exp_proto = exp_q.proto;
    assign exp_tos   = exp_q.tos;

    logic [TS_W-1:0] exp_age;
    assign exp_age = exp_end - exp_start;

    // R9
    exp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_valid && !exp_ready |=> exp_valid && $stable(exp_bytes)
            && $stable(exp_start) && $stable(exp_end) && $stable(exp_idx));

    // R9
    no_accept_in_export_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_valid |-> !in_ready);

    // R9
    one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && (in_op != 2'd3) |=> !in_ready);

    // R5
    aged_over_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exp_valid && exp_aged |-> exp_age > tmo_q);

    // R7
    aged_holds_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(exp_valid) && exp_aged |-> exp_pkts != '0);
endmodule

// File: tb/tb_flow_rec_engine.sv
module tb_flow_rec_engine;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [31:0]  active_timeout = 32'd100;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [3:0]   in_idx = '0;
    logic [1:0]   in_op = '0;
    logic [15:0]  in_len = '0;
    logic [31:0]  in_ts = '0;
    logic [7:0]   in_flags = '0;
    logic [127:0] in_src = '0, in_dst = '0;
    logic [15:0]  in_sport = '0, in_dport = '0;
    logic [7:0]   in_proto = '0, in_tos = '0;
    logic         exp_valid, exp_ready = 1'b0, exp_aged;
    logic [3:0]   exp_idx;
    logic [31:0]  exp_start, exp_end, exp_pkts;
    logic [63:0]  exp_bytes;
    logic [7:0]   exp_flags, exp_proto, exp_tos;
    logic [127:0] exp_src, exp_dst;
    logic [15:0]  exp_sport, exp_dport;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    flow_rec_engine dut (
        .clk(clk), .rst_n(rst_n), .active_timeout(active_timeout),
        .in_valid(in_valid), .in_ready(in_ready), .in_idx(in_idx),
        .in_op(in_op), .in_len(in_len), .in_ts(in_ts), .in_flags(in_flags),
        .in_src(in_src), .in_dst(in_dst), .in_sport(in_sport),
        .in_dport(in_dport), .in_proto(in_proto), .in_tos(in_tos),
        .exp_valid(exp_valid), .exp_ready(exp_ready), .exp_idx(exp_idx),
        .exp_aged(exp_aged), .exp_start(exp_start), .exp_end(exp_end),
        .exp_bytes(exp_bytes), .exp_pkts(exp_pkts), .exp_flags(exp_flags),
        .exp_src(exp_src), .exp_dst(exp_dst), .exp_sport(exp_sport),
        .exp_dport(exp_dport), .exp_proto(exp_proto), .exp_tos(exp_tos)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  idx;
        logic [15:0] len;
        logic [31:0] ts;
        logic [7:0]  flg;
        logic [7:0]  salt;
        logic        xp;
        logic        aged;
        logic        zero;
        logic [31:0] s;
        logic [31:0] e;
        logic [63:0] b;
        logic [31:0] p;
        logic [7:0]  f;
        logic [7:0]  xsalt;
    } vec_t;

    // op: 0 create, 1 update, 2 delete, 3 no-op; timeout fixed at 100
    localparam vec_t VECS [0:14] = '{
        '{2'd0, 4'd1, 16'd60,   32'd1000, 8'h02, 8'h11, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0, 64'd0, 32'd0, 8'h00, 8'h00},
        '{2'd1, 4'd1, 16'd40,   32'd1050, 8'h10, 8'h12, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0, 64'd0, 32'd0, 8'h00, 8'h00},
        '{2'd1, 4'd1, 16'd1500, 32'd1100, 8'h01, 8'h13, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0, 64'd0, 32'd0, 8'h00, 8'h00},
        '{2'd2, 4'd1, 16'd0,    32'd0,    8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 32'd1000, 32'd1100, 64'd1600, 32'd3, 8'h13, 8'h11},
        '{2'd0, 4'd2, 16'd100,  32'd2000, 8'h04, 8'h55, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0, 64'd0, 32'd0, 8'h00, 8'h00},
        '{2'd1, 4'd2, 16'd50,   32'd2101, 8'h08, 8'h66, 1'b1, 1'b1, 1'b0, 32'd2000, 32'd2101, 64'd150, 32'd2, 8'h0C, 8'h55},
        '{2'd3, 4'd2, 16'd999,  32'd9,    8'hFF, 8'h77, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0, 64'd0, 32'd0, 8'h00, 8'h00},
        '{2'd2, 4'd2, 16'd0,    32'd0,    8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 32'd2101, 32'd2101, 64'd50, 32'd1, 8'h08, 8'h66},
        '{2'd2, 4'd1, 16'd0,    32'd0,    8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 32'd0, 32'd0, 64'd0, 32'd0, 8'h00, 8'h00},
        '{2'd0, 4'd3, 16'd10,   32'hFFFFFFF0, 8'h00, 8'h33, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0, 64'd0, 32'd0, 8'h00, 8'h00},
        '{2'd1, 4'd3, 16'd10,   32'h00000020, 8'h80, 8'h34, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0, 64'd0, 32'd0, 8'h00, 8'h00},
        '{2'd2, 4'd3, 16'd0,    32'd0,    8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 32'hFFFFFFF0, 32'h20, 64'd20, 32'd2, 8'h80, 8'h33},
        '{2'd0, 4'd4, 16'd5,    32'hFFFFFFD0, 8'h01, 8'h44, 1'b0, 1'b0, 1'b0, 32'd0, 32'd0, 64'd0, 32'd0, 8'h00, 8'h00},
        '{2'd1, 4'd4, 16'd7,    32'h00000040, 8'h02, 8'h45, 1'b1, 1'b1, 1'b0, 32'hFFFFFFD0, 32'h40, 64'd12, 32'd2, 8'h03, 8'h44},
        '{2'd2, 4'd4, 16'd0,    32'd0,    8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 32'h40, 32'h40, 64'd7, 32'd1, 8'h02, 8'h45}
    };

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] op, input logic [3:0] idx, input logic [15:0] len,
                        input logic [31:0] ts, input logic [7:0] flg, input logic [7:0] salt);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_op = op; in_idx = idx; in_len = len; in_ts = ts;
        in_flags = flg; in_src = {16{salt}}; in_dst = {16{~salt}};
        in_sport = {2{salt}}; in_dport = {salt, 8'h55}; in_proto = salt; in_tos = ~salt;
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic collect(input string tag, input logic [3:0] idx, input logic aged,
                           input logic zero, input logic [31:0] s, input logic [31:0] e,
                           input logic [63:0] b, input logic [31:0] p, input logic [7:0] f,
                           input logic [7:0] salt);
        int n = 0;
        while (!exp_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " R9 export present"}, 128'(exp_valid), 128'(1));
        chk({tag, " R11 idx"}, 128'(exp_idx), 128'(idx));
        chk({tag, " R7/R8 aged flag"}, 128'(exp_aged), 128'(aged));
        chk({tag, " R2/R3 start"}, 128'(exp_start), 128'(s));
        chk({tag, " R3 end"}, 128'(exp_end), 128'(e));
        chk({tag, " R3 bytes"}, 128'(exp_bytes), 128'(b));
        chk({tag, " R3 pkts"}, 128'(exp_pkts), 128'(p));
        chk({tag, " R4 flags"}, 128'(exp_flags), 128'(f));
        chk({tag, " R2/R3 src"}, exp_src, zero ? 128'd0 : {16{salt}});
        chk({tag, " R2/R3 dst"}, exp_dst, zero ? 128'd0 : {16{~salt}});
        chk({tag, " R2/R3 ports"}, 128'({exp_sport, exp_dport}),
            zero ? 128'd0 : 128'({salt, salt, salt, 8'h55}));
        chk({tag, " R2/R3 proto/tos"}, 128'({exp_proto, exp_tos}),
            zero ? 128'd0 : 128'({salt, ~salt}));
        exp_ready = 1'b1;
        @(posedge clk);
        #1 exp_ready = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 in_ready", 128'(in_ready), 128'(1));
        chk("R1 exp_valid", 128'(exp_valid), 128'(0));

        // table walk: R2 R3 R4 R5 R6 R7 R8 R10 R11
        for (int i = 0; i < 15; i++) begin
            send(VECS[i].op, VECS[i].idx, VECS[i].len, VECS[i].ts, VECS[i].flg, VECS[i].salt);
            if (VECS[i].xp) begin
                collect($sformatf("vec%0d", i), VECS[i].idx, VECS[i].aged, VECS[i].zero,
                        VECS[i].s, VECS[i].e, VECS[i].b, VECS[i].p, VECS[i].f, VECS[i].xsalt);
            end else begin
                // R5 R10: no export may appear for this descriptor
                repeat (3) @(negedge clk);
                chk($sformatf("vec%0d R5/R10 no export", i), 128'(exp_valid), 128'(0));
            end
        end

        // R9 stall: hold exp_ready low while a delete export waits
        send(2'd0, 4'd6, 16'd77, 32'd5000, 8'h20, 8'h99);
        send(2'd2, 4'd6, 16'd0, 32'd0, 8'h00, 8'h00);
        repeat (10) @(negedge clk);
        chk("R9 stall valid", 128'(exp_valid), 128'(1));
        chk("R9 stall in_ready", 128'(in_ready), 128'(0));
        chk("R9 stall bytes", 128'(exp_bytes), 128'(77));
        collect("stall", 4'd6, 1'b0, 1'b0, 32'd5000, 32'd5000, 64'd77, 32'd1, 8'h20, 8'h99);
        repeat (3) @(negedge clk);
        chk("R9 ready after release", 128'(in_ready), 128'(1));

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule